// File: doc/BRIEF.md
# Serial Configuration Register Slave with Pointer Read-Back

This block is the serial configuration port of a register bank. A host shifts 32-bit frames on a serial clock and data line, then raises a latch strobe. Each frame holds three fields, MSB first: a 24-bit payload, a 5-bit register index and a 3-bit device select. When the strobe rises after exactly 32 clock edges and the device select matches, the payload is written into the indexed register. The serial clock, strobe and data pins are sampled through synchronizers in the block's own clock domain.

A read takes two frames. The first frame writes a register index into bits [4:0] of register 0. During the second frame the block shifts the selected register out on a shared output pin. At all other times that pin carries a lock-detect status bit taken from an input. The second frame is still committed when its strobe rises, so the host normally resends the same register-0 word. A frame with a foreign device select releases the shared pin through an output-enable, so that another device on the same line can drive it.

Top module: `spi_rb_slave`

## Requirements
- R1: A frame committed with device select 3'b000 writes frame bits [31:8] (the first 24 bits shifted) into the register whose index is frame bits [7:3]. The device select is frame bits [2:0].
- R2: The data line is sampled on rising edges of the serial clock. A change of the data line while the serial clock is high does not alter the captured frame.
- R3: When the strobe rises after any count of rising clock edges other than 32 (31 or 33, for example), no register changes.
- R4: A frame of 32 edges whose device select is not 3'b000 writes nothing and drops `sdo_oe_o` to 0. The output enable returns to 1 when the strobe commits the next frame that carries a matching select.
- R5: A committed write to register 0 arms a read-back. During the next frame, `sdo_o` shows the register indexed by register 0 bits [4:0], MSB first. The 24 register bits come after the first 24 rising edges, and zeros come after edges 25 to 32. Each bit changes shortly after a rising edge.
- R6: During the read-back frame, `sdo_o` ignores `lock_det_i`. After the strobe ends that frame, `sdo_o` follows `lock_det_i` again.
- R7: The read-back frame itself is committed like any other frame. A register-0 write committed during a read-back frame does not arm a further read-back.
- R8: With NUM_REGS = 8, a write to an index of 8 or more changes no register, and a read-back of such an index returns all zeros.
- R9: Reset clears every register, including the read pointer. It selects lock-detect on `sdo_o` and sets `sdo_oe_o` to 1.
- R10: Outside a read-back frame, `sdo_o` equals `lock_det_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| sen_i | input | 1 | Latch strobe, active high, commits on its rising edge |
| sdi_i | input | 1 | Serial data from the host |
| lock_det_i | input | 1 | Lock-detect status shown on the shared output |
| sdo_o | output | 1 | Shared output: lock-detect or read-back data |
| sdo_oe_o | output | 1 | Output enable for the shared pin (0 = released) |

## Verification
The assertions assume that each high and low phase of the serial clock lasts longer than the synchronizer depth plus one block clock, so every edge produces exactly one detected pulse. They also assume that the strobe rises only while the serial clock is low, so a commit never lands in the same cycle as a data shift. The bench holds every serial phase for ten block clocks and changes the data line only in the low phase. The single exception is the rising-edge sampling test, which flips the data three clocks after the rise, well after the sample has been taken.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int FRAME_BITS = 32;
  localparam int DATA_W     = 24;
  localparam int IDX_W      = 5;
  localparam int SEL_W      = 3;
  localparam logic [SEL_W-1:0] DEV_SEL = 3'b000;

  // payload occupies the first bits shifted in
  function automatic logic [DATA_W-1:0] fr_data(input logic [FRAME_BITS-1:0] f);
    return f[FRAME_BITS-1 -: DATA_W];
  endfunction

  function automatic logic [IDX_W-1:0] fr_idx(input logic [FRAME_BITS-1:0] f);
    return f[SEL_W +: IDX_W];
  endfunction

  function automatic logic [SEL_W-1:0] fr_sel(input logic [FRAME_BITS-1:0] f);
    return f[SEL_W-1:0];
  endfunction

  // read-back word: register bits first, zero padding after
  function automatic logic [FRAME_BITS-1:0] rb_word(input logic [DATA_W-1:0] d);
    return {d, {(FRAME_BITS-DATA_W){1'b0}}};
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int g = 1; g < STAGES; g++) st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
  parameter int FRAME_BITS = 32,
  parameter int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_rise,
  input  logic                  sen_rise,
  input  logic                  sdi,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  sdo_bit
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] in_sr, out_sr;
  logic [CNT_W-1:0]      cnt_q;
  logic                  sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr  <= '0;
      out_sr <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      if (sen_rise)                         cnt_q <= '0;
      else if (sck_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (sck_rise) in_sr <= {in_sr[FRAME_BITS-2:0], sdi};
      if (load) begin
        out_sr <= load_word;
        sdo_q  <= 1'b0;
      end else if (sck_rise) begin
        sdo_q  <= out_sr[FRAME_BITS-1];
        out_sr <= {out_sr[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign frame_o = in_sr;
  assign cnt_o   = cnt_q;
  assign sdo_bit = sdo_q;

  // R3: each edge advances the frame count until saturation
  assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise && !sen_rise && cnt_q < CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3: a strobe starts a fresh count
  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise |=> cnt_q == '0);
endmodule

// File: rtl/spi_rb_regbank.sv
module spi_rb_regbank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 24,
  parameter int AW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     ptr_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))    regs[i] <= wr_data;
    end
    // R3/R8: a register moves only when addressed by a commit
    assert_reg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == AW'(i)) |=> $stable(regs[i]));
  end

  // unmapped indices read as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == AW'(i)) rd_data = regs[i];
  end

  assign ptr_o = regs[0][AW-1:0];
endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave #(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic sen_i,
  input  logic sdi_i,
  input  logic lock_det_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  import spi_rb_pkg::*;

  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic [2:0]            pins_s;
  logic                  sck_s, sen_s, sdi_s, sck_d, sen_d;
  logic                  sck_rise, sen_rise;
  logic [FRAME_BITS-1:0] frame, load_word;
  logic [CNT_W-1:0]      cnt;
  logic                  sdo_bit;
  logic                  frame_ok, sel_hit, commit, arm, arm_d;
  logic                  rd_active, desel;
  logic [DATA_W-1:0]     rd_data;
  logic [IDX_W-1:0]      ptr;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, sen_i, sdi_i}), .q(pins_s));

  assign {sck_s, sen_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sen_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      sen_d <= sen_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sen_rise = sen_s & ~sen_d;

  spi_rb_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sen_rise(sen_rise),
    .sdi(sdi_s), .load(arm_d), .load_word(load_word),
    .frame_o(frame), .cnt_o(cnt), .sdo_bit(sdo_bit));

  // frame qualification events
  assign frame_ok = sen_rise && (cnt == CNT_W'(FRAME_BITS));
  assign sel_hit  = fr_sel(frame) == DEV_SEL;
  assign commit   = frame_ok && sel_hit;
  assign arm      = commit && (fr_idx(frame) == '0) && !rd_active;

  spi_rb_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_addr(fr_idx(frame)),
    .wr_data(fr_data(frame)), .rd_addr(ptr), .rd_data(rd_data), .ptr_o(ptr));

  assign load_word = rb_word(rd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_d     <= 1'b0;
      rd_active <= 1'b0;
      desel     <= 1'b0;
    end else begin
      arm_d <= arm;
      if (sen_rise) rd_active <= arm;
      if (frame_ok) desel <= !sel_hit;
    end
  end

  assign sdo_o    = rd_active ? sdo_bit : lock_det_i;
  assign sdo_oe_o = !desel;

  // R6: read-back persists until a strobe
  assert_readback_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active && !sen_rise |=> rd_active);
  // R7: a strobe during read-back always ends it
  assert_no_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active && sen_rise |=> !rd_active);
  // R4: the pin is released only by a strobe
  assert_oe_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe_o) |-> $past(sen_rise));
  // R5: read-back data is never driven into a released pin
  assert_read_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> sdo_oe_o);
endmodule

// File: tb/tb_spi_rb_slave.sv
module tb_spi_rb_slave;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sen = 1'b0, sdi = 1'b0, lock = 1'b0;
  logic sdo, oe;
  int   checks = 0, fails = 0;
  logic [31:0] cap;

  always #2 clk = ~clk;

  spi_rb_slave dut (.clk(clk), .rst_n(rst_n), .sck_i(sck), .sen_i(sen),
    .sdi_i(sdi), .lock_det_i(lock), .sdo_o(sdo), .sdo_oe_o(oe));

  // {index, payload} pairs written then read back
  localparam logic [28:0] VEC [6] = '{
    {5'd1, 24'hA5C3F0}, {5'd2, 24'h000001}, {5'd3, 24'h800000},
    {5'd7, 24'h123456}, {5'd5, 24'hFFFFFF}, {5'd6, 24'h0F0F0F}};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [23:0] d, input logic [4:0] r, input logic [2:0] s);
    return {d, r, s};
  endfunction

  // nbits > 32 pads leading zeros; nbits < 32 drops leading bits
  task automatic frame(input logic [31:0] w, input int nbits, input bit glitch,
                       output logic [31:0] c);
    c = '0;
    for (int i = 0; i < nbits; i++) begin
      int j;
      j = i - (nbits - 32);
      sdi = (j >= 0) ? w[31-j] : 1'b0;
      tick(HALF);
      sck = 1'b1;
      tick(3);
      if (glitch) sdi = ~sdi;
      tick(5);
      c = {c[30:0], sdo};
      tick(HALF - 8);
      sck = 1'b0;
    end
    tick(HALF);
    sen = 1'b1;
    tick(HALF);
    sen = 1'b0;
    tick(HALF);
  endtask

  task automatic wr(input logic [4:0] r, input logic [23:0] d, input bit glitch);
    logic [31:0] c;
    frame(mk(d, r, 3'b000), 32, glitch, c);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] c);
    logic [31:0] dummy;
    frame(mk({19'd0, a}, 5'd0, 3'b000), 32, 1'b0, dummy);
    frame(mk({19'd0, a}, 5'd0, 3'b000), 32, 1'b0, c);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    // R9 / R10: reset state
    lock = 1'b1;
    tick(5);
    chk("R9 sdo lock in reset", {31'd0, sdo}, 32'd1);
    chk("R9 oe in reset", {31'd0, oe}, 32'd1);
    rst_n = 1'b1;
    tick(5);
    lock = 1'b0;
    tick(1);
    chk("R10 sdo follows lock", {31'd0, sdo}, 32'd0);
    rd(5'd4, cap);
    chk("R9 register cleared", cap, 32'd0);

    // R1 / R5: table of writes then read-backs
    for (int k = 0; k < 6; k++) wr(VEC[k][28:24], VEC[k][23:0], 1'b0);
    for (int k = 0; k < 6; k++) begin
      rd(VEC[k][28:24], cap);
      chk("R1 R5 readback", cap, {VEC[k][23:0], 8'h00});
      chk("R5 oe during read", {31'd0, oe}, 32'd1);
    end

    // R2: data flipped during the high phase must not be captured
    wr(5'd4, 24'h3C5A96, 1'b1);
    rd(5'd4, cap);
    chk("R2 rising-edge sample", cap, {24'h3C5A96, 8'h00});

    // R3: short and long frames are discarded
    frame(mk(24'h111111, 5'd1, 3'b000), 31, 1'b0, cap);
    frame(mk(24'h111111, 5'd1, 3'b000), 33, 1'b0, cap);
    rd(5'd1, cap);
    chk("R3 malformed discarded", cap, {24'hA5C3F0, 8'h00});

    // R4: foreign device select
    frame(mk(24'h222222, 5'd2, 3'b101), 32, 1'b0, cap);
    chk("R4 oe released", {31'd0, oe}, 32'd0);
    rd(5'd2, cap);
    chk("R4 no write", cap, {24'h000001, 8'h00});
    chk("R4 oe restored", {31'd0, oe}, 32'd1);

    // R6: lock-detect suppressed during read-back, restored after
    lock = 1'b1;
    rd(5'd6, cap);
    chk("R6 lock ignored", cap, {24'h0F0F0F, 8'h00});
    chk("R6 lock back high", {31'd0, sdo}, 32'd1);
    lock = 1'b0;
    tick(1);
    chk("R6 lock back low", {31'd0, sdo}, 32'd0);

    // R7: read-back frame commits; no re-arm
    frame(mk(24'd5, 5'd0, 3'b000), 32, 1'b0, cap);
    frame(mk(24'h654321, 5'd3, 3'b000), 32, 1'b0, cap);
    chk("R7 readback while writing", cap, {24'hFFFFFF, 8'h00});
    rd(5'd3, cap);
    chk("R7 readback frame committed", cap, {24'h654321, 8'h00});
    lock = 1'b1;
    frame(mk(24'h0000AA, 5'd7, 3'b000), 32, 1'b0, cap);
    chk("R7 no rearm", cap, 32'hFFFFFFFF);
    lock = 1'b0;

    // R8: unmapped index
    wr(5'd9, 24'hABCDEF, 1'b0);
    rd(5'd9, cap);
    chk("R8 unmapped reads zero", cap, 32'd0);
    rd(5'd1, cap);
    chk("R8 no aliasing", cap, {24'hA5C3F0, 8'h00});

    report();
    $finish;
  end
endmodule